// File: doc/BRIEF.md
# Flash Command Admission Gate

This block stands between a command decoder and the executor of a serial flash device. For each decoded opcode it decides whether the command may start now or must be refused. The decision depends on whether an internally self-timed operation is still outstanding. It also depends on which class that operation belongs to and which of the two SRAM buffers it occupies. A status byte is always available. It carries a ready flag and a fixed four-bit density code.

The gate is built around one state machine with five states:

- `GS_READY`: nothing is outstanding.
- `GS_ARM_BUF`: a buffer-bound timed command was admitted and the executor has not yet raised busy.
- `GS_RUN_BUF`: the executor reports busy on that buffer command.
- `GS_ARM_ARR`: the same as `GS_ARM_BUF`, for an array-wide timed command.
- `GS_RUN_ARR`: the executor reports busy on that array-wide command.

The transitions are as follows:

- *launch-buf*: `GS_READY` goes to `GS_ARM_BUF` when a buffer-bound timed command is admitted. The buffer identifier is captured at the same time.
- *launch-arr*: `GS_READY` goes to `GS_ARM_ARR` when an array-wide timed command is admitted.
- *busy-seen*: an ARM state goes to its RUN state when `exec_busy` is high.
- *busy-done*: a RUN state goes back to `GS_READY` when `exec_busy` is low.

Every decision appears as a one-cycle accept or reject pulse in the cycle after the command is presented. A refused command leaves no trace. The surrounding executor is expected to act only on accepted commands.

Top module: `flash_cmd_gate`

## Requirements
- R1: While reset is asserted, `cmd_accept` and `cmd_reject` are 0 and `status_byte` reads 0x9C.
- R2: The status-read opcode D7h is accepted in every state and never changes the state.
- R3: In `GS_READY`, every presented command (`cmd_valid`=1) is accepted. Exactly one of `cmd_accept`/`cmd_reject` pulses, for one cycle, in the cycle after each presented command, and neither pulses otherwise.
- R4: The buffer-bound timed opcodes are 53h, 55h, 58h, 59h, 60h, 61h, 82h, 83h, 85h, 86h, 88h and 89h. Admitting one in `GS_READY` clears status bit 7 from the next cycle and records `cmd_buf` (0 = first buffer, 1 = second buffer).
- R5: While a buffer-bound timed command is outstanding, the plain buffer opcodes 84h, 87h, D1h, D3h, D4h and D6h are accepted when `cmd_buf` differs from the recorded buffer. They are rejected when it matches.
- R6: While a buffer-bound timed command is outstanding, every other opcode except D7h is rejected. This includes array reads such as 03h, array-wide timed opcodes and further buffer-bound timed opcodes.
- R7: The array-wide timed opcodes are 81h, 50h, 7Ch and C7h. Once one is admitted, only D7h is accepted until the gate returns to `GS_READY`.
- R8: `cmd_accept` and `cmd_reject` are never high together. A rejected command changes neither the state nor the recorded buffer.
- R9: From a RUN state, a low `exec_busy` returns the gate to `GS_READY` on the next edge. A command presented in that same cycle is still judged under the old restrictions, and one presented in the following cycle is judged as in `GS_READY`.
- R10: `status_byte` is {ready, 0, density[3:0], 0, 0}. Ready is 1 only in `GS_READY`, and the density code defaults to 0111.
- R11: After a timed command is admitted, a low `exec_busy` does not release the gate until busy has first been seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is presented this cycle |
| cmd_op | input | 8 | Opcode of the presented command |
| cmd_buf | input | BUF_W | Buffer the command addresses (0 first, 1 second) |
| exec_busy | input | 1 | Executor reports a self-timed operation in progress |
| cmd_accept | output | 1 | One-cycle pulse: previous command admitted |
| cmd_reject | output | 1 | One-cycle pulse: previous command refused |
| status_byte | output | 8 | Ready flag and density code |

## Verification
The bench builds the gate with its default parameters: two buffers, a one-bit buffer identifier, density code 0111 and status opcode D7h. With two buffers, every "other buffer" case is reachable from both sides, since timed operations are launched on each buffer in turn. The default density makes the full status byte known in each state. The bench also holds `exec_busy` low after a launch and drops it in the same cycle as a command, which exercises the ARM waiting window and the exact release cycle.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        GS_READY   = 3'd0,
        GS_ARM_BUF = 3'd1,
        GS_RUN_BUF = 3'd2,
        GS_ARM_ARR = 3'd3,
        GS_RUN_ARR = 3'd4
    } gate_state_t;

    typedef enum logic [2:0] {
        OC_STATUS    = 3'd0,
        OC_BUF_TIMED = 3'd1,
        OC_ARR_TIMED = 3'd2,
        OC_BUF_PLAIN = 3'd3,
        OC_OTHER     = 3'd4
    } op_class_t;

endpackage

// File: rtl/flash_op_classify.sv
module flash_op_classify
    import flash_gate_pkg::*;
#(
    parameter logic [OP_W-1:0] STATUS_OP = 8'hD7
) (
    input  logic [OP_W-1:0] op,
    output op_class_t       cls
);

    always_comb begin
        if (op == STATUS_OP) begin
            cls = OC_STATUS;
        end else begin
            unique case (op)
                8'h53, 8'h55, 8'h58, 8'h59,
                8'h60, 8'h61, 8'h82, 8'h83,
                8'h85, 8'h86, 8'h88, 8'h89: cls = OC_BUF_TIMED;
                8'h81, 8'h50, 8'h7C, 8'hC7: cls = OC_ARR_TIMED;
                8'h84, 8'h87, 8'hD1, 8'hD3,
                8'hD4, 8'hD6:               cls = OC_BUF_PLAIN;
                default:                    cls = OC_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/flash_admit_fsm.sv
module flash_admit_fsm
    import flash_gate_pkg::*;
#(
    parameter  int NUM_BUF = 2,
    localparam int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  op_class_t        cls,
    input  logic [BUF_W-1:0] cmd_buf,
    input  logic             exec_busy,
    output logic             accept_o,
    output logic             reject_o,
    output gate_state_t      state_o
);

    gate_state_t      state_q, state_d;
    logic [BUF_W-1:0] buf_q, buf_d;
    logic             admit;
    logic             in_buf_phase, in_arr_phase;

    assign in_buf_phase = (state_q == GS_ARM_BUF) || (state_q == GS_RUN_BUF);
    assign in_arr_phase = (state_q == GS_ARM_ARR) || (state_q == GS_RUN_ARR);

    // Admission decision for the presented command
    always_comb begin
        admit = 1'b0;
        if (cmd_valid) begin
            unique case (state_q)
                GS_READY:               admit = 1'b1;
                GS_ARM_BUF, GS_RUN_BUF: admit = (cls == OC_STATUS) ||
                                                ((cls == OC_BUF_PLAIN) && (cmd_buf != buf_q));
                GS_ARM_ARR, GS_RUN_ARR: admit = (cls == OC_STATUS);
                default:                admit = 1'b0;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        buf_d   = buf_q;
        unique case (state_q)
            GS_READY: begin
                if (admit && (cls == OC_BUF_TIMED)) begin
                    state_d = GS_ARM_BUF;
                    buf_d   = cmd_buf;
                end else if (admit && (cls == OC_ARR_TIMED)) begin
                    state_d = GS_ARM_ARR;
                end
            end
            GS_ARM_BUF: if (exec_busy)  state_d = GS_RUN_BUF;
            GS_RUN_BUF: if (!exec_busy) state_d = GS_READY;
            GS_ARM_ARR: if (exec_busy)  state_d = GS_RUN_ARR;
            GS_RUN_ARR: if (!exec_busy) state_d = GS_READY;
            default:                    state_d = GS_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_READY;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            buf_q   <= buf_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_o <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            accept_o <= admit;
            reject_o <= cmd_valid && !admit;
        end
    end

    assign state_o = state_q;

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && reject_o));

    p_pulse_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o || reject_o) |-> $past(cmd_valid));

    p_status_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cls == OC_STATUS) |=> accept_o);

    p_ready_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_READY && cmd_valid) |=> accept_o);

    p_same_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_buf_phase && cmd_valid && cmd_buf == buf_q && cls != OC_STATUS) |=> reject_o);

    p_array_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_arr_phase && cmd_valid && cls != OC_STATUS) |=> reject_o);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == GS_RUN_BUF || state_q == GS_RUN_ARR) && !exec_busy)
        |=> state_q == GS_READY);

    p_arm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == GS_ARM_BUF || state_q == GS_ARM_ARR) && !exec_busy)
        |=> $stable(state_q));

endmodule

// File: rtl/flash_status_fmt.sv
module flash_status_fmt
    import flash_gate_pkg::*;
#(
    parameter logic [3:0] DENSITY_CODE = 4'b0111
) (
    input  gate_state_t state,
    output logic [7:0]  status
);

    logic ready;

    assign ready  = (state == GS_READY);
    assign status = {ready, 1'b0, DENSITY_CODE, 2'b00};

endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
    import flash_gate_pkg::*;
#(
    parameter  int         NUM_BUF      = 2,
    parameter  logic [3:0] DENSITY_CODE = 4'b0111,
    parameter  logic [7:0] STATUS_OP    = 8'hD7,
    localparam int         BUF_W        = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [BUF_W-1:0] cmd_buf,
    input  logic             exec_busy,
    output logic             cmd_accept,
    output logic             cmd_reject,
    output logic [7:0]       status_byte
);

    op_class_t   op_cls;
    gate_state_t gate_state;

    flash_op_classify #(.STATUS_OP(STATUS_OP)) u_classify (
        .op  (cmd_op),
        .cls (op_cls)
    );

    flash_admit_fsm #(.NUM_BUF(NUM_BUF)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cls       (op_cls),
        .cmd_buf   (cmd_buf),
        .exec_busy (exec_busy),
        .accept_o  (cmd_accept),
        .reject_o  (cmd_reject),
        .state_o   (gate_state)
    );

    flash_status_fmt #(.DENSITY_CODE(DENSITY_CODE)) u_status (
        .state  (gate_state),
        .status (status_byte)
    );

    p_ready_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'h50 && status_byte[7]) |=> !status_byte[7]);

endmodule

// File: tb/flash_cmd_gate_test.sv
module flash_cmd_gate_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_op;
    logic [0:0] cmd_buf;
    logic       exec_busy;
    logic       cmd_accept;
    logic       cmd_reject;
    logic [7:0] status_byte;

    int checks = 0;
    int errors = 0;
    int ms     = 0;   // 0 ready, 1 arm-buf, 2 run-buf, 3 arm-arr, 4 run-arr
    int mbuf   = 0;

    always #4 clk = ~clk;

    flash_cmd_gate uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_buf     (cmd_buf),
        .exec_busy   (exec_busy),
        .cmd_accept  (cmd_accept),
        .cmd_reject  (cmd_reject),
        .status_byte (status_byte)
    );

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // 0 status, 1 buffer timed, 2 array timed, 3 plain buffer, 4 other
    function automatic int op_kind(bit [7:0] op);
        if (op == 8'hD7) return 0;
        if (op inside {8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61,
                       8'h82, 8'h83, 8'h85, 8'h86, 8'h88, 8'h89}) return 1;
        if (op inside {8'h81, 8'h50, 8'h7C, 8'hC7}) return 2;
        if (op inside {8'h84, 8'h87, 8'hD1, 8'hD3, 8'hD4, 8'hD6}) return 3;
        return 4;
    endfunction

    // One clock: drive at a falling edge, check at the next falling edge.
    task automatic cyc(string tag, bit v, bit [7:0] op, int b, bit busy);
        int  k;
        bit  ea;
        bit  er;
        cmd_valid = v;
        cmd_op    = op;
        cmd_buf   = b[0];
        exec_busy = busy;
        k  = op_kind(op);
        ea = 1'b0;
        er = 1'b0;
        if (v) begin
            if (k == 0 || ms == 0 || ((ms == 1 || ms == 2) && k == 3 && b != mbuf))
                ea = 1'b1;
            else
                er = 1'b1;
        end
        if (ms == 0) begin
            if (ea && k == 1) begin ms = 1; mbuf = b; end
            else if (ea && k == 2) ms = 3;
        end else if (ms == 1) begin
            if (busy) ms = 2;
        end else if (ms == 3) begin
            if (busy) ms = 4;
        end else if (!busy) begin
            ms = 0;
        end
        @(negedge clk);
        check(tag, int'(cmd_accept), int'(ea), "accept");
        check(tag, int'(cmd_reject), int'(er), "reject");
        check("R10", int'(status_byte), int'({ms == 0, 1'b0, 4'b0111, 2'b00}), "status");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 8'h00; cmd_buf = 1'b0; exec_busy = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(cmd_accept), 0, "accept in reset");
        check("R1", int'(cmd_reject), 0, "reject in reset");
        check("R1", int'(status_byte), 8'h9C, "status in reset");
        rst_n = 1'b1;

        // R3: everything admitted while ready
        cyc("R3", 1, 8'h03, 0, 0);
        cyc("R3", 1, 8'hD4, 0, 0);
        cyc("R3", 0, 8'h00, 0, 0);
        cyc("R2", 1, 8'hD7, 1, 0);

        // R4: launch on first buffer, busy not yet raised
        cyc("R4", 1, 8'h53, 0, 0);
        cyc("R2", 1, 8'hD7, 0, 0);
        cyc("R5", 1, 8'h84, 1, 0);
        cyc("R5", 1, 8'h84, 0, 0);
        cyc("R11", 0, 8'h00, 0, 0);
        cyc("R11", 1, 8'hD6, 0, 1);
        cyc("R5", 1, 8'h87, 1, 1);
        cyc("R6", 1, 8'h81, 1, 1);
        cyc("R6", 1, 8'h03, 1, 1);
        cyc("R6", 1, 8'h86, 1, 1);
        cyc("R8", 1, 8'hC7, 0, 1);
        cyc("R2", 1, 8'hD7, 0, 1);
        // R9: command in the busy-drop cycle still restricted
        cyc("R9", 1, 8'h03, 1, 0);
        cyc("R9", 1, 8'h50, 0, 0);

        // R7: array-wide operation outstanding
        cyc("R11", 1, 8'h84, 0, 0);
        cyc("R11", 0, 8'h00, 0, 0);
        cyc("R7", 1, 8'h84, 1, 1);
        cyc("R7", 1, 8'hD4, 0, 1);
        cyc("R2", 1, 8'hD7, 1, 1);
        cyc("R7", 1, 8'h88, 0, 1);
        cyc("R8", 1, 8'h53, 1, 1);
        cyc("R9", 0, 8'h00, 0, 0);
        cyc("R9", 1, 8'h0B, 0, 0);

        // Launch on second buffer
        cyc("R4", 1, 8'h86, 1, 0);
        cyc("R5", 1, 8'h84, 0, 1);
        cyc("R5", 1, 8'h87, 1, 1);
        cyc("R5", 1, 8'hD1, 0, 1);
        cyc("R6", 1, 8'h7C, 0, 1);
        cyc("R9", 0, 8'h00, 0, 0);
        cyc("R3", 1, 8'h84, 1, 0);
        cyc("R3", 0, 8'h00, 0, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule